// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block decides, one switching cycle at a time, how a synchronous step-down controller reacts to overcurrent. It sits between the internal pulse-width signal and the two gate drivers. When the internal pulse is high the high-side gate is driven. When it is low the low-side gate is driven, and the voltage across the low-side switch is compared against a programmed limit. That comparison is made only inside a sensing window. The window opens a fixed number of clock cycles after the low-side gate turns on, so switching ringing is ignored, and it closes when the low-side gate turns off.

A strap input picks one of two responses to a trip. In the counted latch-off response, each trip clamps the current: the high-side gate is suppressed and the low-side gate is held on until a second comparator reports that the current has fallen below half the limit. Switching then resumes at the next rising edge of the pulse signal. A third trip in a row with no clean cycle between them shuts both gates off and latches the fault. Only a power-on reset or dropping and re-raising `enable` clears that latch. In the hiccup response, every trip shuts both gates off. The block then waits two soft-start periods, marked by a tick from the startup sequencer, and asks that sequencer for a new soft-start. Protection stays active during the ramp, so a trip there starts a fresh pair of waiting periods at once.

The state machine has six states. IDLE has both gates off and is held while `enable` is low. RUN is normal switching, and soft-start also runs in this state. CLAMP holds the low-side gate on. RESUME waits for the next rising edge of the pulse signal. LATCHED is the final shut-down state. WAIT counts the hiccup periods. Every state goes to IDLE when `enable` is low. The transitions are: IDLE→RUN on enable; RUN→CLAMP on a trip in latch mode before the limit; RUN→LATCHED on the third consecutive trip; RUN→WAIT on a trip in hiccup mode; CLAMP→RESUME when the current is below half the limit; RESUME→RUN on a pulse rising edge; WAIT→RUN on the second soft-start tick.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset with `enable` low, `hs_gate_en`, `ls_gate_en`, `fault_latched` and `restart_req` are all 0.
- R2: In normal switching, `hs_gate_en` equals the value `pwm_in` had at the previous rising clock edge and `ls_gate_en` is its complement. The two gates are never on together.
- R3: `oc_trip` is ignored outside the sensing window. The window opens once the low-side gate has been on for BLANK_CYC clock edges, where BLANK_CYC is 20 by default. A trip sampled at edge BLANK_CYC+1 after the pulse falls is ignored; a trip sampled one edge later is accepted. A low phase lasting BLANK_CYC+1 cycles or less never produces a trip response.
- R4: In latch mode (`mode_hiccup` = 0), the first and second accepted trips put the block in CLAMP, starting at the edge that samples the trip. In CLAMP, `hs_gate_en` is 0 and `ls_gate_en` is 1 whatever `pwm_in` does.
- R5: CLAMP ends when `oc_below_half` is sampled high. After that, the high-side gate stays off and the low-side gate stays on until the next rising edge of `pwm_in`. Normal switching then resumes with the same one-cycle latency as in R2.
- R6: In latch mode, the accepted trip that is the TRIP_LIMIT-th in a row (3 by default) turns both gates off and sets `fault_latched`. This holds regardless of further `pwm_in`, `oc_trip` or `oc_below_half` activity.
- R7: If a low-side interval ends in RUN with no accepted trip, the consecutive-trip count returns to zero. A later trip then clamps again instead of latching.
- R8: The latched fault clears only through reset or through `enable` going low. When `enable` is high again, the block returns to RUN and raises `restart_req` for exactly one cycle.
- R9: In hiccup mode (`mode_hiccup` = 1), an accepted trip turns both gates off and never sets `fault_latched`.
- R10: After a hiccup trip, both gates stay off through the first `ss_tick` pulse. The second pulse returns the block to RUN with `restart_req` high for one cycle.
- R11: `ss_tick` has no effect in RUN. A trip accepted after a restart starts a new count of two ticks from zero.
- R12: `enable` sampled low turns both gates off from the next cycle, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| enable | input | 1 | Controller enable; a low level forces IDLE and clears any latch |
| mode_hiccup | input | 1 | 0 = counted latch-off response, 1 = hiccup-retry response |
| pwm_in | input | 1 | Internal pulse signal; 1 = high-side phase, 0 = low-side phase |
| oc_trip | input | 1 | Low-side overcurrent comparator output |
| oc_below_half | input | 1 | Current below half the programmed limit |
| ss_tick | input | 1 | One-cycle pulse at the end of each soft-start period |
| hs_gate_en | output | 1 | High-side gate drive enable |
| ls_gate_en | output | 1 | Low-side gate drive enable |
| fault_latched | output | 1 | Latch-off fault is active |
| restart_req | output | 1 | One-cycle request for a fresh soft-start |

## Verification
The assertions assume that `mode_hiccup` is a static strap, that `ss_tick` lasts a single cycle, and that all inputs are synchronous to `clk`. The assertions about the latch and the restart pulse also rely on `enable` staying high between trips. The stimulus follows these assumptions. The mode is changed only while `enable` is low, ticks are one-cycle pulses, and every input is driven on the falling clock edge, away from the edge where the design samples. Trip pulses are placed at exact cycle offsets from the falling edge of the pulse signal, so the limit of the sensing window is probed on both sides.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_CLAMP   = 3'd2,
        ST_RESUME  = 3'd3,
        ST_LATCHED = 3'd4,
        ST_WAIT    = 3'd5
    } ocp_state_e;

    typedef enum logic {
        MODE_LATCH  = 1'b0,
        MODE_HICCUP = 1'b1
    } ocp_mode_e;

endpackage

// File: rtl/ocp_blank_window.sv
// Opens the sensing window once the low-side gate has been on for
// BLANK_CYC consecutive clock edges; closes as soon as it turns off.
module ocp_blank_window #(
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_on,
    output logic sense_open
);
    localparam int CW = $clog2(BLANK_CYC + 2);
    localparam logic [CW-1:0] LIM = CW'(BLANK_CYC);

    logic [CW-1:0] on_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_cnt <= '0;
        end else if (!ls_on) begin
            on_cnt <= '0;
        end else if (on_cnt != LIM) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    assign sense_open = ls_on && (on_cnt == LIM);

endmodule

// File: rtl/ocp_trip_counter.sv
// Counts consecutive accepted trips; flags when the next trip is the last.
module ocp_trip_counter #(
    parameter int TRIP_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(TRIP_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIP_LIMIT - 1);

    logic [CW-1:0] trips;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trips <= '0;
        end else if (inc) begin
            if (trips != LAST) begin
                trips <= trips + 1'b1;
            end
        end else if (clear) begin
            trips <= '0;
        end
    end

    assign at_last = (trips == LAST);

endmodule

// File: rtl/ocp_period_counter.sv
// Counts soft-start ticks while armed; reports the tick that ends the wait.
module ocp_period_counter #(
    parameter int N_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(N_PERIODS + 1);
    localparam logic [CW-1:0] LAST = CW'(N_PERIODS - 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (!armed) begin
            seen <= '0;
        end else if (tick && seen != LAST) begin
            seen <= seen + 1'b1;
        end
    end

    assign done = armed && tick && (seen == LAST);

endmodule

// File: rtl/ocp_fault_ctrl.sv
// Per-cycle overcurrent response: blanked sensing, clamp / latch-off
// or hiccup retry, selected by a static strap.
module ocp_fault_ctrl
    import ocp_pkg::*;
#(
    parameter int BLANK_CYC  = 20,
    parameter int TRIP_LIMIT = 3,
    parameter int N_PERIODS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mode_hiccup,
    input  logic pwm_in,
    input  logic oc_trip,
    input  logic oc_below_half,
    input  logic ss_tick,
    output logic hs_gate_en,
    output logic ls_gate_en,
    output logic fault_latched,
    output logic restart_req
);
    ocp_state_e st_q, st_nxt;
    ocp_mode_e  mode;
    logic       pwm_q;
    logic       pwm_rise;
    logic       sense_open;
    logic       trip_ok;
    logic       last_trip;
    logic       trip_clear;
    logic       trip_inc;
    logic       wait_done;
    logic       restart_q;

    assign mode     = mode_hiccup ? MODE_HICCUP : MODE_LATCH;
    assign pwm_rise = pwm_in && !pwm_q;
    assign trip_ok  = (st_q == ST_RUN) && sense_open && oc_trip;

    // Registered copy of the pulse signal; the gates follow this copy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= pwm_in;
        end
    end

    ocp_blank_window #(
        .BLANK_CYC (BLANK_CYC)
    ) blank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ls_on      (ls_gate_en),
        .sense_open (sense_open)
    );

    // A clean low-side interval in RUN (ended by a rising edge) resets the count.
    assign trip_inc   = trip_ok && (mode == MODE_LATCH);
    assign trip_clear = (st_q == ST_IDLE) || (mode == MODE_HICCUP) ||
                        ((st_q == ST_RUN) && pwm_rise && !trip_ok);

    ocp_trip_counter #(
        .TRIP_LIMIT (TRIP_LIMIT)
    ) trips_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (trip_clear),
        .inc     (trip_inc),
        .at_last (last_trip)
    );

    ocp_period_counter #(
        .N_PERIODS (N_PERIODS)
    ) periods_i (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (st_q == ST_WAIT),
        .tick  (ss_tick),
        .done  (wait_done)
    );

    // Next-state decision.
    always_comb begin
        st_nxt = st_q;
        if (!enable) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_nxt = ST_RUN;
                end
                ST_RUN: begin
                    if (trip_ok) begin
                        if (mode == MODE_HICCUP) begin
                            st_nxt = ST_WAIT;
                        end else if (last_trip) begin
                            st_nxt = ST_LATCHED;
                        end else begin
                            st_nxt = ST_CLAMP;
                        end
                    end
                end
                ST_CLAMP: begin
                    if (oc_below_half) begin
                        st_nxt = ST_RESUME;
                    end
                end
                ST_RESUME: begin
                    if (pwm_rise) begin
                        st_nxt = ST_RUN;
                    end
                end
                ST_LATCHED: begin
                    st_nxt = ST_LATCHED;
                end
                ST_WAIT: begin
                    if (wait_done) begin
                        st_nxt = ST_RUN;
                    end
                end
                default: begin
                    st_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // State register and restart pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            restart_q <= 1'b0;
        end else begin
            st_q      <= st_nxt;
            restart_q <= (st_nxt == ST_RUN) &&
                         ((st_q == ST_IDLE) || (st_q == ST_WAIT));
        end
    end

    // Outputs.
    always_comb begin
        hs_gate_en    = 1'b0;
        ls_gate_en    = 1'b0;
        fault_latched = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                hs_gate_en = 1'b0;
                ls_gate_en = 1'b0;
            end
            ST_RUN: begin
                hs_gate_en = pwm_q;
                ls_gate_en = !pwm_q;
            end
            ST_CLAMP, ST_RESUME: begin
                hs_gate_en = 1'b0;
                ls_gate_en = 1'b1;
            end
            ST_LATCHED: begin
                fault_latched = 1'b1;
            end
            ST_WAIT: begin
                hs_gate_en = 1'b0;
                ls_gate_en = 1'b0;
            end
            default: begin
                hs_gate_en = 1'b0;
                ls_gate_en = 1'b0;
            end
        endcase
    end

    assign restart_req = restart_q;

endmodule

// File: rtl/ocp_fault_ctrl_chk.sv
module ocp_fault_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic mode_hiccup,
    input logic pwm_in,
    input logic hs_gate_en,
    input logic ls_gate_en,
    input logic fault_latched,
    input logic restart_req
);
    AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_en && ls_gate_en)); // R2

    AST_HS_FROM_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_en) |-> $past(pwm_in)); // R5

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> (!hs_gate_en && !ls_gate_en)); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && enable) |=> fault_latched); // R8

    AST_HICCUP_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hiccup |-> !fault_latched); // R9

    AST_RESTART_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req); // R10

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_gate_en && !ls_gate_en)); // R12

endmodule

bind ocp_fault_ctrl ocp_fault_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .mode_hiccup   (mode_hiccup),
    .pwm_in        (pwm_in),
    .hs_gate_en    (hs_gate_en),
    .ls_gate_en    (ls_gate_en),
    .fault_latched (fault_latched),
    .restart_req   (restart_req)
);

// File: tb/ocp_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module ocp_fault_ctrl_tb_top;
    localparam int B = 20;

    logic clk = 1'b0;
    logic rst_n, enable, mode_hiccup, pwm_in, oc_trip, oc_below_half, ss_tick;
    logic hs_gate_en, ls_gate_en, fault_latched, restart_req;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    ocp_fault_ctrl #(.BLANK_CYC(B), .TRIP_LIMIT(3), .N_PERIODS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_hiccup(mode_hiccup),
        .pwm_in(pwm_in), .oc_trip(oc_trip), .oc_below_half(oc_below_half),
        .ss_tick(ss_tick), .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en),
        .fault_latched(fault_latched), .restart_req(restart_req)
    );

    task automatic step();
        @(negedge clk);
    endtask

    // Compares {hs, ls, fault, restart}.
    task automatic chk(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {hs_gate_en, ls_gate_en, fault_latched, restart_req};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {hs,ls,flt,rst} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic high_phase(input int len);
        for (int i = 0; i < len; i++) begin
            pwm_in = 1'b1;
            step();
        end
    endtask

    // Low phase of len cycles; oc_trip driven at offset trip_j, or throughout.
    task automatic low_phase(input int trip_j, input int len, input bit trip_all);
        for (int j = 0; j < len; j++) begin
            pwm_in  = 1'b0;
            oc_trip = trip_all || (j == trip_j);
            step();
        end
        oc_trip = 1'b0;
    endtask

    task automatic release_clamp();
        high_phase(2);
        chk(4'b0100, "R4 clamp holds low side on while pwm high");
        oc_below_half = 1'b1;
        step();
        oc_below_half = 1'b0;
        step();
        step();
        chk(4'b0100, "R5 high side waits for pwm rising edge");
        pwm_in = 1'b0;
        step();
        step();
        chk(4'b0100, "R5 low side held before resume");
        pwm_in = 1'b1;
        step();
        chk(4'b1000, "R5 switching resumes on rising edge");
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b0; mode_hiccup = 1'b0; pwm_in = 1'b0;
        oc_trip = 1'b0; oc_below_half = 1'b0; ss_tick = 1'b0;
        step();
        chk(4'b0000, "R1 in reset");
        step();
        rst_n = 1'b1;
        step();
        step();
        chk(4'b0000, "R1 after reset, disabled");
    endtask

    task automatic t_normal();
        enable = 1'b1;
        step();
        chk(4'b0101, "R8 start raises restart_req");
        step();
        chk(4'b0100, "R2 low phase, restart_req dropped");
        pwm_in = 1'b1;
        step();
        chk(4'b1000, "R2 high side follows pwm");
        pwm_in = 1'b0;
        step();
        chk(4'b0100, "R2 low side follows pwm");
    endtask

    task automatic t_blank();
        oc_trip = 1'b1;
        high_phase(3);
        chk(4'b1000, "R3 trip ignored in high phase");
        oc_trip = 1'b0;
        low_phase(B, B + 3, 1'b0);
        pwm_in = 1'b1;
        step();
        chk(4'b1000, "R3 trip at blank edge ignored");
        high_phase(2);
        low_phase(-1, B + 1, 1'b1);
        pwm_in = 1'b1;
        step();
        chk(4'b1000, "R3 short low pulse gives no sample");
    endtask

    task automatic t_latch_seq();
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        chk(4'b0100, "R4 first trip clamps");
        release_clamp();
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        chk(4'b0100, "R4 second trip clamps");
        release_clamp();
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        chk(4'b0010, "R6 third trip latches");
        high_phase(3);
        chk(4'b0010, "R6 latched ignores pwm");
        oc_below_half = 1'b1;
        step();
        oc_below_half = 1'b0;
        step();
        chk(4'b0010, "R6 latched ignores below-half");
    endtask

    task automatic t_disable();
        pwm_in = 1'b0;
        enable = 1'b0;
        step();
        chk(4'b0000, "R8 disable clears latch");
        enable = 1'b1;
        step();
        chk(4'b0101, "R8 re-enable restarts");
        pwm_in = 1'b1;
        step();
        chk(4'b1000, "R8 switching after restart");
        enable = 1'b0;
        step();
        chk(4'b0000, "R12 disable from run");
        enable = 1'b1;
        step();
        chk(4'b1001, "R12 restart with pwm high");
    endtask

    task automatic t_counter_reset();
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        release_clamp();
        high_phase(2);
        low_phase(-1, B + 3, 1'b0);
        high_phase(2);
        chk(4'b1000, "R7 clean cycle completes");
        low_phase(B + 1, B + 3, 1'b0);
        release_clamp();
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        pwm_in = 1'b1;
        step();
        chk(4'b0100, "R7 count restarted, clamp not latch");
        release_clamp();
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        chk(4'b0010, "R7 third trip after reset latches");
    endtask

    task automatic t_hiccup();
        enable = 1'b0;
        step();
        mode_hiccup = 1'b1;
        pwm_in = 1'b0;
        enable = 1'b1;
        step();
        chk(4'b0101, "R10 hiccup mode start");
        high_phase(2);
        low_phase(B + 1, B + 3, 1'b0);
        chk(4'b0000, "R9 hiccup trip turns both off");
        high_phase(3);
        chk(4'b0000, "R9 off while waiting, no latch");
        ss_tick = 1'b1;
        step();
        ss_tick = 1'b0;
        step();
        chk(4'b0000, "R10 still off after one period");
        ss_tick = 1'b1;
        pwm_in = 1'b0;
        step();
        chk(4'b0101, "R10 second period restarts");
        ss_tick = 1'b0;
        step();
        chk(4'b0100, "R10 restart pulse single cycle");
        ss_tick = 1'b1;
        step();
        ss_tick = 1'b0;
        pwm_in = 1'b1;
        step();
        chk(4'b1000, "R11 tick ignored in run");
        low_phase(B + 1, B + 3, 1'b0);
        chk(4'b0000, "R11 trip during ramp");
        ss_tick = 1'b1;
        step();
        ss_tick = 1'b0;
        step();
        chk(4'b0000, "R11 fresh pair needs two ticks");
        ss_tick = 1'b1;
        pwm_in = 1'b0;
        step();
        ss_tick = 1'b0;
        chk(4'b0101, "R11 restart after fresh pair");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_blank();
        t_latch_seq();
        t_disable();
        t_counter_reset();
        t_hiccup();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule